// File: doc/BRIEF.md
# Quad-channel DAC serial command front-end

This block is the digital command front end of a four-channel, 16-bit digital-to-analog converter. A host shifts 24-bit command words in over a three-wire serial link: a serial clock, a data line and an active-low frame select. The block samples data on each falling serial-clock edge while the frame select is low. After the 24th bit it splits the word into a data word, a channel address, a load-mode field and a power-down flag.

Every channel has two registers: a staging buffer and the DAC register that drives the converter. A command can write the staging buffer and stop there. It can also load the addressed channel's DAC register, or load all four DAC registers from their buffers in the same cycle, which gives simultaneous updates across channels. The serial inputs are sampled by the block's own system clock through synchronizers, so the serial clock must run well below the system clock.

Top module: `quad_dac_fe`

## Requirements
- R1: After reset every DAC register output is zero, `update_o` is low and `pd_o` is low.
- R2: A frame is 24 bits, sent most significant bit first. Each bit is taken on a falling edge of `sclk_i` while `sync_ni` is low. Bits 15:0 carry the data word, MSB first.
- R3: Bits 18:17 address the channel. 00 is channel A (`dac_o[15:0]`), 01 is B (`dac_o[31:16]`), 10 is C (`dac_o[47:32]`) and 11 is D (`dac_o[63:48]`). Bits 23, 22 and 19 are ignored.
- R4: Load mode bits 21:20 = 00 writes only the addressed buffer. No DAC register changes and `update_o` stays low.
- R5: Load mode 01 writes the addressed buffer and loads that channel's DAC register with the new word. The other three DAC registers keep their values.
- R6: Load mode 10 writes the addressed buffer and loads all four DAC registers from their buffers in one cycle. The addressed channel receives the new word.
- R7: Load mode 11 is reserved. It changes no buffer, no DAC register and not `pd_o`.
- R8: If `sync_ni` rises before the 24th falling edge, the frame is dropped and no state changes.
- R9: Each new low period of `sync_ni` starts a fresh 24-bit count. Falling edges after the 24th in the same frame are ignored.
- R10: Every load event pulses `update_o` high for exactly one system clock cycle. `dac_o` changes only in a cycle where `update_o` is high.
- R11: `pd_o` holds bit 16 of the last accepted frame that did not use the reserved load mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial inputs |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data taken on its falling edge |
| sync_ni | input | 1 | Active-low frame select |
| din_i | input | 1 | Serial data, MSB first |
| dac_o | output | 64 | Four DAC registers, channel A in the low 16 bits |
| update_o | output | 1 | One-cycle pulse when DAC registers are loaded |
| pd_o | output | 1 | Captured power-down flag |

## Verification
The assertions assume well-formed host traffic. Each `sclk_i` level lasts at least a few system clocks, `din_i` is stable across every falling serial edge, and frames are separated by many system cycles. Under these assumptions two load pulses can never fall in adjacent cycles. The stimulus holds every serial level for three system clocks and keeps `sync_ni` low for four clocks around each frame. It sweeps all channel and load-mode pairs over several data patterns, then adds truncated frames, over-long frames and reserved codes.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned CH_W    = $clog2(NUM_CH);
  localparam int unsigned FRAME_W = 24;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
  // field positions within the frame
  localparam int unsigned PD_POS  = DATA_W;
  localparam int unsigned SEL_LSB = DATA_W + 1;
  localparam int unsigned LD_LSB  = 20;

  typedef enum logic [1:0] {
    LD_BUF = 2'b00,
    LD_ONE = 2'b01,
    LD_ALL = 2'b10,
    LD_RSV = 2'b11
  } ld_mode_e;

  typedef struct packed {
    ld_mode_e             mode;
    logic [CH_W-1:0]      sel;
    logic                 pd;
    logic [DATA_W-1:0]    data;
  } cmd_t;

  function automatic cmd_t decode_frame(input logic [FRAME_W-1:0] f);
    cmd_t c;
    c.mode = ld_mode_e'(f[LD_LSB +: 2]);
    c.sel  = f[SEL_LSB +: CH_W];
    c.pd   = f[PD_POS];
    c.data = f[DATA_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= RST_VAL;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
  import quad_dac_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sync_ni,
  input  logic               din_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   bit_cnt_o
);
  logic               sclk_q;
  logic               sclk_fall;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               vld_q;

  assign sclk_fall = sclk_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (sync_ni) begin
        // frame select idle: drop any partial frame
        cnt_q <= '0;
      end else if (sclk_fall && (cnt_q < CNT_W'(FRAME_W))) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], din_i};
        cnt_q   <= cnt_q + 1'b1;
        vld_q   <= (cnt_q == CNT_W'(FRAME_W - 1));
      end
    end
  end

  assign frame_vld_o = vld_q;
  assign frame_o     = shreg_q;
  assign bit_cnt_o   = cnt_q;
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
  import quad_dac_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_vld_i,
  input  cmd_t                     cmd_i,
  output logic [NUM_CH*DATA_W-1:0] dac_o,
  output logic [NUM_CH-1:0]        load_en_o,
  output logic                     update_o,
  output logic                     pd_o
);
  logic [NUM_CH-1:0] wr_en;
  logic [NUM_CH-1:0] ld_en;
  logic              accept;
  logic              upd_q;
  logic              pd_q;

  assign accept = cmd_vld_i && (cmd_i.mode != LD_RSV);

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic [DATA_W-1:0] buf_q;
      logic [DATA_W-1:0] dac_q;
      logic [DATA_W-1:0] buf_nxt;

      assign wr_en[c] = accept && (cmd_i.sel == CH_W'(c));
      assign ld_en[c] = accept &&
                        ((cmd_i.mode == LD_ALL) ||
                         ((cmd_i.mode == LD_ONE) && (cmd_i.sel == CH_W'(c))));
      // load sees the word written in the same cycle
      assign buf_nxt  = wr_en[c] ? cmd_i.data : buf_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          buf_q <= '0;
          dac_q <= '0;
        end else begin
          buf_q <= buf_nxt;
          if (ld_en[c]) dac_q <= buf_nxt;
        end
      end

      assign dac_o[c*DATA_W +: DATA_W] = dac_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      upd_q <= |ld_en;
      if (accept) pd_q <= cmd_i.pd;
    end
  end

  assign load_en_o = ld_en;
  assign update_o  = upd_q;
  assign pd_o      = pd_q;
endmodule

// File: rtl/quad_dac_fe.sv
module quad_dac_fe
  import quad_dac_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     sync_ni,
  input  logic                     din_i,
  output logic [NUM_CH*DATA_W-1:0] dac_o,
  output logic                     update_o,
  output logic                     pd_o
);
  logic [2:0]         ser_s;
  logic               frame_vld;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   bit_cnt;
  logic [NUM_CH-1:0]  load_en;
  cmd_t               cmd;

  qdac_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, sync_ni, din_i}),
    .q_o    (ser_s)
  );

  qdac_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (ser_s[2]),
    .sync_ni     (ser_s[1]),
    .din_i       (ser_s[0]),
    .frame_vld_o (frame_vld),
    .frame_o     (frame_q),
    .bit_cnt_o   (bit_cnt)
  );

  assign cmd = decode_frame(frame_q);

  qdac_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_vld_i (frame_vld),
    .cmd_i     (cmd),
    .dac_o     (dac_o),
    .load_en_o (load_en),
    .update_o  (update_o),
    .pd_o      (pd_o)
  );
endmodule

// File: rtl/quad_dac_fe_chk.sv
module quad_dac_fe_chk
  import quad_dac_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CH*DATA_W-1:0] dac_o,
  input logic                     update_o,
  input logic                     frame_vld,
  input cmd_t                     cmd,
  input logic [NUM_CH-1:0]        load_en,
  input logic [CNT_W-1:0]         bit_cnt
);
  assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(FRAME_W));

  assert_buf_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && cmd.mode == LD_BUF) |=> !update_o);

  assert_one_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && cmd.mode == LD_ONE) |-> ($countones(load_en) == 1));

  assert_all_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && cmd.mode == LD_ALL) |-> (&load_en));

  assert_rsv_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && cmd.mode == LD_RSV) |=> (!update_o && $stable(dac_o)));

  assert_update_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  assert_dac_needs_update_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_o != $past(dac_o)) |-> update_o);

  assert_no_load_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld |-> (load_en == '0));
endmodule

bind quad_dac_fe quad_dac_fe_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dac_o     (dac_o),
  .update_o  (update_o),
  .frame_vld (frame_vld),
  .cmd       (cmd),
  .load_en   (load_en),
  .bit_cnt   (bit_cnt)
);

// File: tb/quad_dac_fe_tb_top.sv
module quad_dac_fe_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        sync_n = 1'b1;
  logic        din = 1'b0;
  logic [63:0] dac;
  logic        upd;
  logic        pd;

  int n_run = 0;
  int n_fail = 0;
  int pulse_cnt = 0;
  bit done = 1'b0;

  logic [15:0] buf_m [4];
  logic [15:0] dac_m [4];
  logic        pd_m;

  always #4 clk = ~clk;

  quad_dac_fe dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sclk_i   (sclk),
    .sync_ni  (sync_n),
    .din_i    (din),
    .dac_o    (dac),
    .update_o (upd),
    .pd_o     (pd)
  );

  always @(negedge clk) if (rst_n && upd) pulse_cnt++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] model_dac();
    return {dac_m[3], dac_m[2], dac_m[1], dac_m[0]};
  endfunction

  function automatic logic [23:0] mk(input logic [1:0] ld, input logic [1:0] ch,
                                     input logic p, input logic [15:0] d,
                                     input logic [2:0] junk);
    return {junk[2:1], ld, junk[0], ch, p, d};
  endfunction

  task automatic run_frame(input logic [23:0] f, input int nbits, input string req);
    int start;
    int exp_p;
    logic [1:0] ld;
    logic [1:0] ch;
    ld = f[21:20];
    ch = f[18:17];
    @(negedge clk);
    start = pulse_cnt;
    sync_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 24) ? f[23-i] : ~f[0];
      repeat (3) @(negedge clk);
      sclk = 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (4) @(negedge clk);
    sync_n = 1'b1;
    repeat (10) @(negedge clk);
    exp_p = 0;
    if (nbits >= 24 && ld != 2'b11) begin
      buf_m[ch] = f[15:0];
      pd_m = f[16];
      if (ld == 2'b01) begin
        dac_m[ch] = buf_m[ch];
        exp_p = 1;
      end else if (ld == 2'b10) begin
        for (int k = 0; k < 4; k++) dac_m[k] = buf_m[k];
        exp_p = 1;
      end
    end
    check(dac === model_dac(), req, "dac_o (R2 R3)", dac, model_dac());
    check((pulse_cnt - start) == exp_p, "R10", "update pulses",
          64'(pulse_cnt - start), 64'(exp_p));
    check(pd === pd_m, "R11", "pd_o", 64'(pd), 64'(pd_m));
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      buf_m[k] = '0;
      dac_m[k] = '0;
    end
    pd_m = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(dac === 64'h0, "R1", "reset dac_o", dac, 64'h0);
    check(upd === 1'b0, "R1", "reset update_o", 64'(upd), 64'h0);
    check(pd === 1'b0, "R1", "reset pd_o", 64'(pd), 64'h0);

    // sweep every channel/mode pair over several data patterns
    for (int p = 0; p < 3; p++) begin
      for (int ch = 0; ch < 4; ch++) begin
        for (int ld = 0; ld < 4; ld++) begin
          logic [15:0] d;
          string r;
          case (p)
            0: d = 16'hFFFF ^ 16'(ch * 16'h0101 + ld);
            1: d = 16'h8001 + 16'(ch << 4) + 16'(ld << 9);
            default: d = 16'(16'h1357 * (ch + 1) + 16'h2468 * ld);
          endcase
          case (ld)
            0: r = "R4";
            1: r = "R5";
            2: r = "R6";
            default: r = "R7";
          endcase
          run_frame(mk(2'(ld), 2'(ch), 1'((ch + p) & 1), d, 3'(p * 3 + ch)), 24, r);
        end
      end
    end

    // truncated frames are dropped
    for (int n = 0; n < 24; n += 5) begin
      run_frame(mk(2'b10, 2'(n), 1'b1, 16'hDEAD ^ 16'(n), 3'b000), n, "R8");
    end
    run_frame(mk(2'b01, 2'b11, 1'b1, 16'hBEEF, 3'b111), 23, "R8");
    // buffers untouched by dropped frames: reveal all through a load-all
    run_frame(mk(2'b10, 2'b00, 1'b0, 16'h0F0F, 3'b000), 24, "R8");

    // partial then full frame: count restarts; extra edges ignored
    run_frame(mk(2'b01, 2'b10, 1'b0, 16'h5555, 3'b000), 11, "R9");
    run_frame(mk(2'b01, 2'b01, 1'b1, 16'hA5C3, 3'b000), 24, "R9");
    run_frame(mk(2'b01, 2'b11, 1'b0, 16'h3C3C, 3'b000), 27, "R9");
    run_frame(mk(2'b10, 2'b10, 1'b1, 16'h0001, 3'b101), 30, "R9");
    run_frame(mk(2'b11, 2'b00, 1'b0, 16'hFFFF, 3'b000), 24, "R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule